// File: doc/BRIEF.md
# Dual-Direction Stack Pointer Unit with Limit Detection

This block holds the three 6-bit pointers that share one 64-word stack RAM. The first is a subroutine stack pointer, which grows upward. The second and third are a local and a global register-stack pointer, which grow downward. Each cycle an operation code selects one pointer action: push, pop, load, read, add or subtract. The block then drives the RAM address, the write enable and the write data for that cycle. A select input picks which of the two register-stack pointers the register-stack operations act on. The global pointer can also be saved to and restored from the subroutine stack.

A 4-bit limit register, padded with two low bits, marks an overflow threshold. The low bits are `00` for subroutine pushes and `11` for register pushes. When the pointer produced by a push lands on that threshold, a latched interrupt request is raised. The request is cleared only by the operation that loads the limit. That same operation also loads a 4-bit vector pointer, which is brought out as an output.

Top module: `stk_ptr_unit`

## Requirements
- R1: After the asynchronous reset all three pointers read as 0, the overflow request is low and the vector pointer is 0.
- R2: A subroutine push (op 1) increments the subroutine pointer, writes `data_i` at the incremented address with `ram_we_o` high. A subroutine pop (op 2) addresses the current pointer, passes `ram_rdata_i` to `rd_data_o`, then decrements. Op 5 decrements without a RAM write. `ram_we_o` is high only on ops 1, 6 and 14.
- R3: A register push (op 6) decrements the selected register pointer and writes `data_i` at the decremented address. A register pop (op 7) addresses the current register pointer, passes `ram_rdata_i` to `rd_data_o`, then increments.
- R4: Register-stack ops (6 to 12) act on the local pointer when `sel_glob_i` is 0 and on the global pointer when it is 1. The unselected pointer does not change.
- R5: Op 10 adds 4, 1, 2 or 3 to the selected register pointer for `idx_i` values 0, 1, 2 and 3. Op 11 subtracts 1 and op 12 subtracts 4, in both cases without a RAM write.
- R6: All pointer arithmetic wraps modulo 64.
- R7: Op 3 loads the subroutine pointer and op 8 loads the selected register pointer, both from `data_i[5:0]`. Op 4 (subroutine) and op 9 (selected register) drive the pointer on `rd_data_o[5:0]`.
- R8: The overflow request sets when a subroutine push (op 1 or 14) produces a pointer equal to {limit,2'b00}. It also sets when a register push (op 6) produces a pointer equal to {limit,2'b11}. Once set, it stays high until cleared.
- R9: Op 13 loads the limit from `data_i[5:2]` and the vector pointer from `data_i[15:12]`, and clears the overflow request. The new values take effect from the next cycle.
- R10: Op 14 increments the subroutine pointer and writes the zero-extended global pointer at the new address. Op 15 addresses the current subroutine pointer, loads the global pointer from `ram_rdata_i[5:0]` and decrements the subroutine pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code (0 means no operation) |
| idx_i | input | 2 | Add amount selector for op 10 |
| sel_glob_i | input | 1 | Register-stack pointer select: 0 local, 1 global |
| data_i | input | 16 | Data for pushes and pointer/limit loads |
| ram_rdata_i | input | 16 | Data read from the stack RAM |
| ram_addr_o | output | 6 | Stack RAM address |
| ram_we_o | output | 1 | Stack RAM write enable |
| ram_wdata_o | output | 16 | Stack RAM write data |
| rd_data_o | output | 16 | Pointer read value or popped RAM word |
| vec_ptr_o | output | 4 | Vector pointer loaded by op 13 |
| ovf_irq_o | output | 1 | Latched stack-overflow request |

## Verification
The bench builds the block with its default widths: 6-bit pointers, a 4-bit limit and a 16-bit data path. With these widths, wrap-around at both ends of the 64-word space takes only a single load and a push or pop. Every limit threshold is also reachable from a pointer load followed by one push. This lets the bench cover several cases in a short run:
- overflow at the top of the register stack, where a push from 0 wraps onto threshold 63;
- a subroutine push that lands on the register-push threshold and must not trigger overflow;
- every `idx_i` code of the add operation, including the wrap past 63.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_SS_PUSH = 4'd1,
    OP_SS_POP  = 4'd2,
    OP_SS_WR   = 4'd3,
    OP_SS_RD   = 4'd4,
    OP_SS_DEC  = 4'd5,
    OP_RS_PUSH = 4'd6,
    OP_RS_POP  = 4'd7,
    OP_RS_WR   = 4'd8,
    OP_RS_RD   = 4'd9,
    OP_RS_ADD  = 4'd10,
    OP_RS_SUB1 = 4'd11,
    OP_RS_SUB4 = 4'd12,
    OP_LIM_LD  = 4'd13,
    OP_GS_PUSH = 4'd14,
    OP_GS_POP  = 4'd15
  } sp_op_e;
endpackage

// File: rtl/stk_ptr_next.sv
module stk_ptr_next
  import sp_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  sp_op_e             op_i,
  input  logic [1:0]         idx_i,
  input  logic               sel_glob_i,
  input  logic [PTR_W-1:0]   wr_val_i,
  input  logic [PTR_W-1:0]   pop_val_i,
  input  logic [PTR_W-1:0]   ssp_i,
  input  logic [PTR_W-1:0]   lsp_i,
  input  logic [PTR_W-1:0]   gsp_i,
  output logic [PTR_W-1:0]   ssp_d_o,
  output logic [PTR_W-1:0]   lsp_d_o,
  output logic [PTR_W-1:0]   gsp_d_o,
  output logic [PTR_W-1:0]   addr_o,
  output logic               we_o,
  output logic               ss_push_o,
  output logic               rs_push_o,
  output logic [PTR_W-1:0]   ss_new_o,
  output logic [PTR_W-1:0]   rs_new_o
);
  logic [PTR_W-1:0] rsp, ss_inc, ss_dec, rs_inc, rs_dec, add_amt, rs_d;
  logic             gsp_pop;

  assign rsp     = sel_glob_i ? gsp_i : lsp_i;
  assign ss_inc  = ssp_i + PTR_W'(1);
  assign ss_dec  = ssp_i - PTR_W'(1);
  assign rs_inc  = rsp + PTR_W'(1);
  assign rs_dec  = rsp - PTR_W'(1);
  // index code 0 stands for 4
  assign add_amt = (idx_i == 2'd0) ? PTR_W'(4) : PTR_W'(idx_i);

  always_comb begin
    ssp_d_o   = ssp_i;
    rs_d      = rsp;
    addr_o    = ssp_i;
    we_o      = 1'b0;
    ss_push_o = 1'b0;
    rs_push_o = 1'b0;
    gsp_pop   = 1'b0;
    case (op_i)
      OP_SS_PUSH, OP_GS_PUSH: begin
        ssp_d_o = ss_inc; addr_o = ss_inc; we_o = 1'b1; ss_push_o = 1'b1;
      end
      OP_SS_POP:  ssp_d_o = ss_dec;
      OP_GS_POP:  begin ssp_d_o = ss_dec; gsp_pop = 1'b1; end
      OP_SS_WR:   ssp_d_o = wr_val_i;
      OP_SS_DEC:  ssp_d_o = ss_dec;
      OP_RS_PUSH: begin
        rs_d = rs_dec; addr_o = rs_dec; we_o = 1'b1; rs_push_o = 1'b1;
      end
      OP_RS_POP:  begin rs_d = rs_inc; addr_o = rsp; end
      OP_RS_WR:   rs_d = wr_val_i;
      OP_RS_ADD:  rs_d = rsp + add_amt;
      OP_RS_SUB1: rs_d = rs_dec;
      OP_RS_SUB4: rs_d = rsp - PTR_W'(4);
      default: ;
    endcase
  end

  assign lsp_d_o  = sel_glob_i ? lsp_i : rs_d;
  assign gsp_d_o  = gsp_pop ? pop_val_i : (sel_glob_i ? rs_d : gsp_i);
  assign ss_new_o = ss_inc;
  assign rs_new_o = rs_dec;
endmodule

// File: rtl/stk_limit_unit.sv
module stk_limit_unit #(
  parameter int PTR_W = 6,
  parameter int LIM_W = 4,
  parameter int VEC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lim_ld_i,
  input  logic [LIM_W-1:0] lim_val_i,
  input  logic [VEC_W-1:0] vec_val_i,
  input  logic             ss_push_i,
  input  logic             rs_push_i,
  input  logic [PTR_W-1:0] ss_new_i,
  input  logic [PTR_W-1:0] rs_new_i,
  output logic             ovf_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int LOW_W = PTR_W - LIM_W;

  logic [LIM_W-1:0] lim_q;
  logic             ss_hit, rs_hit;

  assign ss_hit = ss_push_i && (ss_new_i == {lim_q, {LOW_W{1'b0}}});
  assign rs_hit = rs_push_i && (rs_new_i == {lim_q, {LOW_W{1'b1}}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= '0;
      vec_o <= '0;
      ovf_o <= 1'b0;
    end else if (lim_ld_i) begin
      lim_q <= lim_val_i;
      vec_o <= vec_val_i;
      ovf_o <= 1'b0;
    end else if (ss_hit || rs_hit) begin
      ovf_o <= 1'b1;
    end
  end
endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit
  import sp_pkg::*;
#(
  parameter int PTR_W  = 6,
  parameter int LIM_W  = 4,
  parameter int VEC_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        op_i,
  input  logic [1:0]        idx_i,
  input  logic              sel_glob_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [PTR_W-1:0]  ram_addr_o,
  output logic              ram_we_o,
  output logic [DATA_W-1:0] ram_wdata_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [VEC_W-1:0]  vec_ptr_o,
  output logic              ovf_irq_o
);
  localparam int LOW_W = PTR_W - LIM_W;
  localparam int PAD_W = DATA_W - PTR_W;

  sp_op_e           op;
  logic [PTR_W-1:0] ssp_q, lsp_q, gsp_q, ssp_d, lsp_d, gsp_d;
  logic [PTR_W-1:0] ss_new, rs_new, rsp;
  logic             ss_push, rs_push;

  assign op  = sp_op_e'(op_i);
  assign rsp = sel_glob_i ? gsp_q : lsp_q;

  stk_ptr_next #(.PTR_W(PTR_W)) u_next (
    .op_i      (op),
    .idx_i     (idx_i),
    .sel_glob_i(sel_glob_i),
    .wr_val_i  (data_i[PTR_W-1:0]),
    .pop_val_i (ram_rdata_i[PTR_W-1:0]),
    .ssp_i     (ssp_q),
    .lsp_i     (lsp_q),
    .gsp_i     (gsp_q),
    .ssp_d_o   (ssp_d),
    .lsp_d_o   (lsp_d),
    .gsp_d_o   (gsp_d),
    .addr_o    (ram_addr_o),
    .we_o      (ram_we_o),
    .ss_push_o (ss_push),
    .rs_push_o (rs_push),
    .ss_new_o  (ss_new),
    .rs_new_o  (rs_new)
  );

  stk_limit_unit #(.PTR_W(PTR_W), .LIM_W(LIM_W), .VEC_W(VEC_W)) u_lim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lim_ld_i (op == OP_LIM_LD),
    .lim_val_i(data_i[LOW_W +: LIM_W]),
    .vec_val_i(data_i[DATA_W-1 -: VEC_W]),
    .ss_push_i(ss_push),
    .rs_push_i(rs_push),
    .ss_new_i (ss_new),
    .rs_new_i (rs_new),
    .ovf_o    (ovf_irq_o),
    .vec_o    (vec_ptr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ssp_q <= '0;
      lsp_q <= '0;
      gsp_q <= '0;
    end else begin
      ssp_q <= ssp_d;
      lsp_q <= lsp_d;
      gsp_q <= gsp_d;
    end
  end

  assign ram_wdata_o = (op == OP_GS_PUSH) ? {{PAD_W{1'b0}}, gsp_q} : data_i;

  always_comb begin
    case (op)
      OP_SS_RD:             rd_data_o = {{PAD_W{1'b0}}, ssp_q};
      OP_RS_RD:             rd_data_o = {{PAD_W{1'b0}}, rsp};
      OP_SS_POP, OP_RS_POP: rd_data_o = ram_rdata_i;
      default:              rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/stk_ptr_unit_chk.sv
module stk_ptr_unit_chk
  import sp_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       op_i,
  input logic             sel_glob_i,
  input logic             ram_we_o,
  input logic [PTR_W-1:0] ram_addr_o,
  input logic             ovf_irq_o,
  input logic [PTR_W-1:0] ssp_q,
  input logic [PTR_W-1:0] lsp_q,
  input logic [PTR_W-1:0] gsp_q
);
  logic rs_op;
  assign rs_op = (op_i >= OP_RS_PUSH) && (op_i <= OP_RS_SUB4);

  p_ss_push_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SS_PUSH) |=> (ssp_q == $past(ssp_q) + PTR_W'(1)));

  p_we_push_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (op_i == OP_SS_PUSH || op_i == OP_RS_PUSH || op_i == OP_GS_PUSH));

  p_rs_push_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_RS_PUSH && !sel_glob_i) |-> (ram_addr_o == lsp_q - PTR_W'(1)));

  p_glob_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_op && !sel_glob_i) |=> $stable(gsp_q));

  p_loc_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_op && sel_glob_i) |=> $stable(lsp_q));

  p_ovf_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_irq_o && op_i != OP_LIM_LD) |=> ovf_irq_o);

  p_ovf_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LIM_LD) |=> !ovf_irq_o);
endmodule

bind stk_ptr_unit stk_ptr_unit_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .sel_glob_i(sel_glob_i),
  .ram_we_o  (ram_we_o),
  .ram_addr_o(ram_addr_o),
  .ovf_irq_o (ovf_irq_o),
  .ssp_q     (ssp_q),
  .lsp_q     (lsp_q),
  .gsp_q     (gsp_q)
);

// File: tb/stk_ptr_unit_tb.sv
module stk_ptr_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  idx_i = '0;
  logic        sel_glob_i = 1'b0;
  logic [15:0] data_i = '0;
  logic [15:0] ram_rdata_i = '0;
  logic [5:0]  ram_addr_o;
  logic        ram_we_o;
  logic [15:0] ram_wdata_o;
  logic [15:0] rd_data_o;
  logic [3:0]  vec_ptr_o;
  logic        ovf_irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  stk_ptr_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .idx_i(idx_i),
    .sel_glob_i(sel_glob_i), .data_i(data_i), .ram_rdata_i(ram_rdata_i),
    .ram_addr_o(ram_addr_o), .ram_we_o(ram_we_o), .ram_wdata_o(ram_wdata_o),
    .rd_data_o(rd_data_o), .vec_ptr_o(vec_ptr_o), .ovf_irq_o(ovf_irq_o)
  );

  typedef struct {
    string       req;
    logic [5:0]  addr;
    bit          chk_addr;
    logic        we;
    logic [15:0] wdata;
    logic [15:0] rd;
    bit          chk_rd;
    logic        ovf;
    logic [3:0]  vec;
  } exp_t;

  exp_t q[$];

  // reference model state
  logic [5:0] m_ssp = 0, m_lsp = 0, m_gsp = 0;
  logic [3:0] m_lim = 0, m_vec = 0;
  logic       m_ovf = 0;

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    #3;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, "we", 16'(ram_we_o), 16'(e.we));
      chk(e.req, "ovf", 16'(ovf_irq_o), 16'(e.ovf));
      chk(e.req, "vec", 16'(vec_ptr_o), 16'(e.vec));
      if (e.chk_addr) chk(e.req, "addr", 16'(ram_addr_o), 16'(e.addr));
      if (e.we) chk(e.req, "wdata", ram_wdata_o, e.wdata);
      if (e.chk_rd) chk(e.req, "rd", rd_data_o, e.rd);
    end
  end

  task automatic do_op(string req, logic [3:0] op, logic [1:0] idx, logic sel,
                       logic [15:0] d, logic [15:0] rdat);
    exp_t e;
    logic [5:0] rsp, nr;
    @(negedge clk_i);
    op_i = op; idx_i = idx; sel_glob_i = sel; data_i = d; ram_rdata_i = rdat;
    rsp = sel ? m_gsp : m_lsp;
    nr  = rsp;
    e.req = req; e.addr = 0; e.chk_addr = 0; e.we = 0; e.wdata = d;
    e.rd = 0; e.chk_rd = 0; e.ovf = m_ovf; e.vec = m_vec;
    case (op)
      4'd1, 4'd14: begin
        e.addr = m_ssp + 6'd1; e.chk_addr = 1; e.we = 1;
        if (op == 4'd14) e.wdata = {10'd0, m_gsp};
        if (e.addr == {m_lim, 2'b00}) m_ovf = 1;
        m_ssp = m_ssp + 6'd1;
      end
      4'd2: begin
        e.addr = m_ssp; e.chk_addr = 1; e.rd = rdat; e.chk_rd = 1;
        m_ssp = m_ssp - 6'd1;
      end
      4'd15: begin
        e.addr = m_ssp; e.chk_addr = 1;
        m_gsp = rdat[5:0]; m_ssp = m_ssp - 6'd1;
      end
      4'd3: m_ssp = d[5:0];
      4'd4: begin e.rd = {10'd0, m_ssp}; e.chk_rd = 1; end
      4'd5: m_ssp = m_ssp - 6'd1;
      4'd6: begin
        nr = rsp - 6'd1; e.addr = nr; e.chk_addr = 1; e.we = 1;
        if (nr == {m_lim, 2'b11}) m_ovf = 1;
      end
      4'd7: begin e.addr = rsp; e.chk_addr = 1; e.rd = rdat; e.chk_rd = 1; nr = rsp + 6'd1; end
      4'd8: nr = d[5:0];
      4'd9: begin e.rd = {10'd0, rsp}; e.chk_rd = 1; end
      4'd10: nr = rsp + ((idx == 2'd0) ? 6'd4 : 6'(idx));
      4'd11: nr = rsp - 6'd1;
      4'd12: nr = rsp - 6'd4;
      4'd13: begin m_lim = d[5:2]; m_vec = d[15:12]; m_ovf = 0; end
      default: ;
    endcase
    if (op >= 4'd6 && op <= 4'd12) begin
      if (sel) m_gsp = nr; else m_lsp = nr;
    end
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk_i);
    op_i = 4'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    do_op("R1", 4'd4, 0, 0, 0, 0);
    do_op("R1", 4'd9, 0, 0, 0, 0);
    do_op("R1", 4'd9, 0, 1, 0, 0);
    // R9 limit 9, vector 10
    do_op("R9", 4'd13, 0, 0, 16'hA024, 0);
    // R2 subroutine push/pop/dec
    do_op("R2", 4'd1, 0, 0, 16'h1111, 0);
    do_op("R2", 4'd1, 0, 0, 16'h2222, 0);
    do_op("R2", 4'd1, 0, 0, 16'h3333, 0);
    do_op("R2", 4'd2, 0, 0, 0, 16'hBEEF);
    do_op("R2", 4'd5, 0, 0, 0, 0);
    do_op("R7", 4'd4, 0, 0, 0, 0);
    // R8 subroutine overflow at 36, then held
    do_op("R7", 4'd3, 0, 0, 16'h0023, 0);
    do_op("R8", 4'd1, 0, 0, 16'h4444, 0);
    do_op("R8", 4'd1, 0, 0, 16'h5555, 0);
    do_op("R8", 4'd0, 0, 0, 0, 0);
    // R9 clear, limit 15, vector 3
    do_op("R9", 4'd13, 0, 0, 16'h303C, 0);
    // R6/R8 register push wraps 0 -> 63, hits {15,11}
    do_op("R6", 4'd6, 0, 0, 16'h6666, 0);
    do_op("R8", 4'd13, 0, 0, 16'h0000, 0);
    // R5 adds with wrap
    do_op("R5", 4'd10, 2'd0, 0, 0, 0);
    do_op("R5", 4'd10, 2'd1, 0, 0, 0);
    do_op("R5", 4'd10, 2'd2, 0, 0, 0);
    do_op("R5", 4'd10, 2'd3, 0, 0, 0);
    do_op("R5", 4'd9, 0, 0, 0, 0);
    do_op("R4", 4'd9, 0, 1, 0, 0);
    // R4 global pointer path
    do_op("R7", 4'd8, 0, 1, 16'h0010, 0);
    do_op("R5", 4'd11, 0, 1, 0, 0);
    do_op("R5", 4'd12, 0, 1, 0, 0);
    do_op("R3", 4'd7, 0, 1, 0, 16'h1234);
    do_op("R3", 4'd6, 0, 1, 16'h7777, 0);
    do_op("R4", 4'd9, 0, 1, 0, 0);
    do_op("R4", 4'd9, 0, 0, 0, 0);
    // R10 global save and restore
    do_op("R10", 4'd14, 0, 0, 0, 0);
    do_op("R10", 4'd15, 0, 0, 0, 16'h0027);
    do_op("R10", 4'd9, 0, 1, 0, 0);
    do_op("R10", 4'd4, 0, 0, 0, 0);
    // R6 subroutine wrap both ends
    do_op("R6", 4'd3, 0, 0, 16'h003F, 0);
    do_op("R6", 4'd1, 0, 0, 16'h8888, 0);
    do_op("R6", 4'd3, 0, 0, 16'h0000, 0);
    do_op("R6", 4'd2, 0, 0, 0, 16'h4321);
    do_op("R6", 4'd4, 0, 0, 0, 0);
    // R8 limit 2: subroutine push to 11 must not flag, register push to 11 must
    do_op("R9", 4'd13, 0, 0, 16'h0008, 0);
    do_op("R8", 4'd3, 0, 0, 16'h000A, 0);
    do_op("R8", 4'd1, 0, 0, 16'h9999, 0);
    do_op("R8", 4'd8, 0, 0, 16'h000C, 0);
    do_op("R8", 4'd6, 0, 0, 16'hAAAA, 0);
    do_op("R8", 4'd0, 0, 0, 0, 0);
    do_op("R3", 4'd7, 0, 0, 0, 16'h5A5A);
    do_op("R3", 4'd9, 0, 0, 0, 0);
    idle();
    idle();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule